// File: doc/BRIEF.md
# BCD time-of-day clock counter

This block keeps the time of day as three packed-BCD bytes: hours, minutes and seconds. It is fed a periodic tick, one system-clock cycle wide, and a prescaler inside it turns every `TICKS_PER_SEC` ticks into one step of the seconds byte. A 50 Hz tick, made by dividing a 2.5 MHz clock by 50000, with the default prescale of 50 gives one-second steps. The three bytes can drive display decoders directly.

Seconds and minutes count 00 to 59 and hours count 00 to 23. A step of the seconds byte past 59 carries into minutes, and a step of minutes past 59 carries into hours. The whole carry chain settles within one clock edge, so 23:59:59 becomes 00:00:00 in a single cycle. A load strobe presets all three bytes at once, for example to 23:58:55 to exercise the rollover path. A load also restarts the sub-second count.

Each cycle the control logic picks one of four actions. ACT_IDLE means no tick and no load, so everything holds. ACT_FRACTION means a tick that only advances the sub-second count. ACT_SECOND means a tick that completes a second and steps the seconds byte, with cascaded carries. ACT_LOAD means a load, which wins over any tick in the same cycle. There are no other states or transitions. The action is chosen afresh every cycle from the inputs and the sub-second count.

Top module: `tod_clock`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, hours_o, minutes_o and seconds_o are 8'h00, and the sub-second count is 0.
- R2: seconds_o steps once for every `TICKS_PER_SEC` clock cycles in which tick_i is high. Consecutive high cycles each count as one tick. The step appears on the clock edge that samples the final tick.
- R3: In a cycle with neither tick_i nor load_i high, all three outputs keep their values.
- R4: Each byte holds the tens digit in bits [7:4] and the units digit in bits [3:0]. A step from a units digit of 9 gives units 0 and tens plus one, so every output nibble stays in the range 0 to 9.
- R5: A step of seconds from 8'h59 gives 8'h00 and steps minutes on the same edge. A step of minutes from 8'h59 gives 8'h00 and steps hours on the same edge. Neither byte ever exceeds 8'h59.
- R6: A carry into hours at 8'h23 gives 8'h00, so 23:59:59 becomes 00:00:00. Hours never exceed 8'h23.
- R7: load_i high writes load_hours_i, load_minutes_i and load_seconds_i to the outputs on the next edge. The loaded values must be valid packed BCD within the limits. The load also clears the sub-second count, so a full `TICKS_PER_SEC` ticks are needed for the next seconds step.
- R8: A tick in the same cycle as a load is discarded. The outputs take the loaded values, and the sub-second count is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One tick per high cycle |
| load_i | input | 1 | Preset strobe for all three bytes |
| load_hours_i | input | 8 | Packed-BCD hours to preset |
| load_minutes_i | input | 8 | Packed-BCD minutes to preset |
| load_seconds_i | input | 8 | Packed-BCD seconds to preset |
| hours_o | output | 8 | Packed-BCD hours, 00 to 23 |
| minutes_o | output | 8 | Packed-BCD minutes, 00 to 59 |
| seconds_o | output | 8 | Packed-BCD seconds, 00 to 59 |

## Verification
The bench builds the clock with `TICKS_PER_SEC` set to 3 instead of 50. At that value the prescaler terminal count, the restart after a load, and the consecutive-tick case all take only a few cycles to reach. The short second also allows a full hour of minute carries to be run. Every hour boundary, including the midnight wrap, is reached by presetting hh:59:59 and applying a single second of ticks.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef logic [7:0] bcd_byte_t;

    typedef enum logic [1:0] {
        ACT_IDLE     = 2'd0,
        ACT_FRACTION = 2'd1,
        ACT_SECOND   = 2'd2,
        ACT_LOAD     = 2'd3
    } tod_action_e;

    localparam bcd_byte_t SEXAGESIMAL_TOP = 8'h59;
    localparam bcd_byte_t HOURS_TOP       = 8'h23;

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int TICKS_PER_SEC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic second_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] frac_q;
    logic          at_last;

    assign at_last  = (frac_q == LAST);
    assign second_o = tick_i && at_last && !clear_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frac_q <= '0;
        end else if (clear_i) begin
            frac_q <= '0;
        end else if (tick_i) begin
            if (at_last) frac_q <= '0;
            else         frac_q <= frac_q + 1'b1;
        end
    end
endmodule

// File: rtl/tod_bcd_byte.sv
module tod_bcd_byte
    import tod_pkg::*;
#(
    parameter bcd_byte_t LIMIT = 8'h59
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  bcd_byte_t load_val_i,
    input  logic      step_i,
    output bcd_byte_t value_o,
    output logic      wrap_o
);
    bcd_byte_t value_q;
    bcd_byte_t value_d;
    logic      at_limit;

    assign at_limit = (value_q >= LIMIT);
    assign wrap_o   = step_i && at_limit && !load_i;
    assign value_o  = value_q;

    always_comb begin
        value_d = value_q;
        if (load_i) begin
            value_d = load_val_i;
        end else if (step_i) begin
            if (at_limit) begin
                value_d = 8'h00;
            end else if (value_q[3:0] >= 4'd9) begin
                value_d = {value_q[7:4] + 4'd1, 4'd0};
            end else begin
                value_d = {value_q[7:4], value_q[3:0] + 4'd1};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value_q <= 8'h00;
        else        value_q <= value_d;
    end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int TICKS_PER_SEC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] load_hours_i,
    input  logic [7:0] load_minutes_i,
    input  logic [7:0] load_seconds_i,
    output logic [7:0] hours_o,
    output logic [7:0] minutes_o,
    output logic [7:0] seconds_o
);
    tod_action_e action;
    logic second_done;
    logic sec_step, load_all;
    logic sec_wrap, min_wrap, hrs_wrap;

    tod_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescale (
        .clk(clk), .rst_n(rst_n), .clear_i(load_i), .tick_i(tick_i),
        .second_o(second_done)
    );

    always_comb begin
        if (load_i)           action = ACT_LOAD;
        else if (second_done) action = ACT_SECOND;
        else if (tick_i)      action = ACT_FRACTION;
        else                  action = ACT_IDLE;
    end

    always_comb begin
        sec_step = 1'b0;
        load_all = 1'b0;
        unique case (action)
            ACT_IDLE:     ;
            ACT_FRACTION: ;
            ACT_SECOND:   sec_step = 1'b1;
            ACT_LOAD:     load_all = 1'b1;
        endcase
    end

    tod_bcd_byte #(.LIMIT(SEXAGESIMAL_TOP)) u_seconds (
        .clk(clk), .rst_n(rst_n), .load_i(load_all), .load_val_i(load_seconds_i),
        .step_i(sec_step), .value_o(seconds_o), .wrap_o(sec_wrap)
    );

    tod_bcd_byte #(.LIMIT(SEXAGESIMAL_TOP)) u_minutes (
        .clk(clk), .rst_n(rst_n), .load_i(load_all), .load_val_i(load_minutes_i),
        .step_i(sec_wrap), .value_o(minutes_o), .wrap_o(min_wrap)
    );

    tod_bcd_byte #(.LIMIT(HOURS_TOP)) u_hours (
        .clk(clk), .rst_n(rst_n), .load_i(load_all), .load_val_i(load_hours_i),
        .step_i(min_wrap), .value_o(hours_o), .wrap_o(hrs_wrap)
    );

    logic unused_wrap;
    assign unused_wrap = hrs_wrap;
endmodule

// File: rtl/tod_clock_checker.sv
module tod_clock_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       load_i,
    input logic [7:0] load_hours_i,
    input logic [7:0] load_minutes_i,
    input logic [7:0] load_seconds_i,
    input logic [7:0] hours_o,
    input logic [7:0] minutes_o,
    input logic [7:0] seconds_o
);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> ($stable(hours_o) && $stable(minutes_o) && $stable(seconds_o)));

    p_digits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hours_o[3:0] <= 4'd9) && (minutes_o[3:0] <= 4'd9) && (seconds_o[3:0] <= 4'd9));

    p_limits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seconds_o <= 8'h59) && (minutes_o <= 8'h59));

    p_sec_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && seconds_o == 8'h59) |=> ((seconds_o != 8'h00) || (minutes_o != $past(minutes_o))));

    p_hours_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hours_o <= 8'h23);

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (hours_o == $past(load_hours_i) && minutes_o == $past(load_minutes_i)
                    && seconds_o == $past(load_seconds_i)));
endmodule

bind tod_clock tod_clock_checker u_tod_clock_checker (.*);

// File: tb/tod_clock_bench.sv
module tod_clock_bench;
    localparam int TPS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] lh = 8'h00, lm = 8'h00, ls = 8'h00;
    logic [7:0] hours_o, minutes_o, seconds_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tod_clock #(.TICKS_PER_SEC(TPS)) u_tod_clock (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
        .load_hours_i(lh), .load_minutes_i(lm), .load_seconds_i(ls),
        .hours_o(hours_o), .minutes_o(minutes_o), .seconds_o(seconds_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic check(input string req, input logic [23:0] exp);
        logic [23:0] got;
        got = {hours_o, minutes_o, seconds_o};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
        end
    endtask

    task automatic preset(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        lh = h; lm = m; ls = s; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 during reset", 24'h000000);
        @(negedge clk) rst_n = 1'b1;
        check("R1 after release", 24'h000000);
        ticks(TPS - 1);
        check("R1 prescaler from zero", 24'h000000);
        ticks(1);
        check("R1 first second", 24'h000001);
    endtask

    task automatic t_prescale;
        preset(8'h12, 8'h34, 8'h20);
        check("R7 preset", 24'h123420);
        ticks(TPS - 1);
        check("R2 before terminal tick", 24'h123420);
        ticks(1);
        check("R2 terminal tick", 24'h123421);
        @(negedge clk) tick_i = 1'b1;
        repeat (TPS) @(negedge clk);
        tick_i = 1'b0;
        check("R2 consecutive ticks", 24'h123422);
        repeat (10) @(negedge clk);
        check("R3 idle hold", 24'h123422);
    endtask

    task automatic t_load_clear;
        preset(8'h01, 8'h02, 8'h03);
        ticks(TPS - 1);
        preset(8'h04, 8'h05, 8'h06);
        ticks(TPS - 1);
        check("R7 load clears sub-second", 24'h040506);
        ticks(1);
        check("R7 full count after load", 24'h040507);
    endtask

    task automatic t_load_priority;
        preset(8'h07, 8'h08, 8'h09);
        ticks(TPS - 1);
        @(negedge clk);
        lh = 8'h10; lm = 8'h20; ls = 8'h30; load_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0; tick_i = 1'b0;
        check("R8 load wins over tick", 24'h102030);
        ticks(TPS - 1);
        check("R8 tick discarded", 24'h102030);
        ticks(1);
        check("R8 next second", 24'h102031);
    endtask

    task automatic t_digits;
        preset(8'h00, 8'h00, 8'h09);
        ticks(TPS);
        check("R4 units carry", 24'h000010);
        preset(8'h00, 8'h00, 8'h00);
        for (int s = 1; s < 60; s++) begin
            ticks(TPS);
            check("R4 seconds sweep", {16'h0000, to_bcd(s)});
        end
        ticks(TPS);
        check("R5 seconds wrap", 24'h000100);
    endtask

    task automatic t_cascade;
        preset(8'h00, 8'h09, 8'h59);
        ticks(TPS);
        check("R5 minute units carry", 24'h001000);
        preset(8'h00, 8'h00, 8'h00);
        for (int m = 1; m <= 60; m++) begin
            ticks(60 * TPS);
            check("R5 minute sweep", (m == 60) ? 24'h010000 : {8'h00, to_bcd(m), 8'h00});
        end
    endtask

    task automatic t_hours;
        for (int h = 0; h < 24; h++) begin
            preset(to_bcd(h), 8'h59, 8'h59);
            ticks(TPS);
            check("R6 hour step", {to_bcd((h + 1) % 24), 16'h0000});
        end
        preset(8'h23, 8'h58, 8'h55);
        ticks(65 * TPS);
        check("R6 midnight from preset", 24'h000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_prescale();
        t_load_clear();
        t_load_priority();
        t_digits();
        t_cascade();
        t_hours();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule